// File: doc/BRIEF.md
# Multi-Cycle Accumulator Processor Core

This block is a small processor built around one accumulator. It moves through its work as a state machine. Each instruction starts with a fetch, carried out as separate register transfers. First the program counter is copied into the memory address register. Next a read is issued on the single memory port. Then the returned word is latched into the memory data register while the program counter advances by one. A decode step moves that word into the instruction register, which splits it into a 4-bit opcode (bits 15:12) and a 12-bit operand (bits 11:0). An execute step then carries out the operation, and control goes back to fetch.

There are six instructions. Add and compare take the operand as an immediate value. Load and store take the operand as a direct word address. Jump loads the operand into the program counter. A halt instruction parks the core until the next reset. All internal registers and the compare flags are brought out on debug outputs. The memory behind the port answers a read one clock after the read strobe.

Top module: `acc_core`

## Requirements
- R1: Fetch copies the program counter into the address register, then holds memRd high for one cycle with memAddr equal to that value, then latches the returned word into the data register (dbgMdr).
- R2: The program counter rises by exactly 1 at the end of the fetch, so dbgPc already shows the incremented value while the instruction is decoded.
- R3: Decode moves the fetched word into the instruction register (dbgIr); bits 15:12 select the operation and bits 11:0 are the operand.
- R4: Opcode 3 (add) adds the zero-extended operand to the accumulator, modulo 2^16.
- R5: Opcode 1 (load) reads the word at the operand address and places it in the accumulator.
- R6: Opcode 2 (store) raises memWr for exactly one cycle, with memAddr equal to the operand and memWdata equal to the accumulator.
- R7: Opcode 4 (compare) sets dbgEq when the accumulator equals the zero-extended operand, and sets dbgLt when it is unsigned-less than the operand. The accumulator is left unchanged.
- R8: Opcode 5 (jump) loads the operand into the program counter, so the next fetch reads from that address.
- R9: Opcode 15 (halt) raises halted. From then on there is no memory access and no register change until reset.
- R10: Every other opcode changes nothing except the program counter increment done during fetch.
- R11: Reset clears the program counter, accumulator and both flags, drops both strobes and halted, and restarts at fetch. The first read strobe follows one cycle after reset is released.
- R12: Add, compare, jump, halt and no-op instructions take 5 clock cycles, store takes 6 and load takes 7. memRd and memWr are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| memAddr | output | 12 | Memory word address, driven from the address register |
| memRd | output | 1 | Read strobe; data is expected on memRdata one cycle later |
| memWr | output | 1 | Write strobe, one cycle per store |
| memWdata | output | 16 | Write data, equal to the accumulator |
| memRdata | input | 16 | Read data from memory |
| halted | output | 1 | High after a halt instruction |
| dbgPc | output | 12 | Program counter |
| dbgAcc | output | 16 | Accumulator |
| dbgMar | output | 12 | Memory address register |
| dbgMdr | output | 16 | Memory data register |
| dbgIr | output | 16 | Instruction register |
| dbgEq | output | 1 | Equal flag from the last compare |
| dbgLt | output | 1 | Unsigned less-than flag from the last compare |

## Verification
The ports only show architectural state at instruction boundaries, so the hardest points to observe are the internal fetch steps and the point where a jump overrides the fetch increment. The bench derives cycle-exact sample points from the per-instruction cycle counts. It probes the first fetch cycle by cycle, checking the read strobe, the address and the data register before decode. The program places a jump whose target is far from the next sequential address, and a store follows at that target, so a wrong override shows up both in dbgPc and in memory contents.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

  localparam logic [3:0] OPC_LOAD  = 4'd1;
  localparam logic [3:0] OPC_STORE = 4'd2;
  localparam logic [3:0] OPC_ADD   = 4'd3;
  localparam logic [3:0] OPC_CMP   = 4'd4;
  localparam logic [3:0] OPC_JUMP  = 4'd5;
  localparam logic [3:0] OPC_HALT  = 4'd15;

  typedef enum logic [3:0] {
    PH_FETCH_MAR,
    PH_FETCH_READ,
    PH_FETCH_CAPT,
    PH_DECODE,
    PH_EXEC,
    PH_MEM_READ,
    PH_MEM_BACK,
    PH_MEM_WRITE,
    PH_HALT
  } phase_e;

  typedef struct packed {
    logic marFromPc;
    logic marFromOpd;
    logic memRead;
    logic memWrite;
    logic mdrCapture;
    logic pcInc;
    logic irLoad;
    logic accAdd;
    logic accLoad;
    logic flagsSet;
    logic pcJump;
  } ctrl_t;

endpackage

// File: rtl/acc_control.sv
module acc_control
  import acc_core_pkg::*;
#(
  parameter int OP_W = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [OP_W-1:0] opcode,
  output ctrl_t           ctrl,
  output logic            halted
);

  phase_e phase, phaseNxt;

  always_ff @(posedge clk) begin
    if (!rstN) phase <= PH_FETCH_MAR;
    else       phase <= phaseNxt;
  end

  always_comb begin
    ctrl     = '0;
    phaseNxt = phase;
    case (phase)
      PH_FETCH_MAR: begin
        ctrl.marFromPc = 1'b1;
        phaseNxt = PH_FETCH_READ;
      end
      PH_FETCH_READ: begin
        ctrl.memRead = 1'b1;
        phaseNxt = PH_FETCH_CAPT;
      end
      PH_FETCH_CAPT: begin
        ctrl.mdrCapture = 1'b1;
        ctrl.pcInc      = 1'b1;
        phaseNxt = PH_DECODE;
      end
      PH_DECODE: begin
        ctrl.irLoad = 1'b1;
        phaseNxt = PH_EXEC;
      end
      PH_EXEC: begin
        phaseNxt = PH_FETCH_MAR;
        case (opcode)
          OPC_LOAD: begin
            ctrl.marFromOpd = 1'b1;
            phaseNxt = PH_MEM_READ;
          end
          OPC_STORE: begin
            ctrl.marFromOpd = 1'b1;
            phaseNxt = PH_MEM_WRITE;
          end
          OPC_ADD:  ctrl.accAdd   = 1'b1;
          OPC_CMP:  ctrl.flagsSet = 1'b1;
          OPC_JUMP: ctrl.pcJump   = 1'b1;
          OPC_HALT: phaseNxt = PH_HALT;
          default:  phaseNxt = PH_FETCH_MAR;
        endcase
      end
      PH_MEM_READ: begin
        ctrl.memRead = 1'b1;
        phaseNxt = PH_MEM_BACK;
      end
      PH_MEM_BACK: begin
        ctrl.mdrCapture = 1'b1;
        ctrl.accLoad    = 1'b1;
        phaseNxt = PH_FETCH_MAR;
      end
      PH_MEM_WRITE: begin
        ctrl.memWrite = 1'b1;
        phaseNxt = PH_FETCH_MAR;
      end
      PH_HALT:  phaseNxt = PH_HALT;
      default:  phaseNxt = PH_FETCH_MAR;
    endcase
  end

  assign halted = (phase == PH_HALT);

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    phase == PH_HALT |=> phase == PH_HALT && ctrl == '0); // R9
  AST_EXEC_AFTER_DECODE: assert property (@(posedge clk) disable iff (!rstN)
    phase == PH_DECODE |=> phase == PH_EXEC); // R3
  AST_CAPT_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    phase == PH_FETCH_READ |=> ctrl.mdrCapture && ctrl.pcInc); // R1

endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
  import acc_core_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12,
  parameter int OP_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctrl,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRd,
  output logic              memWr,
  output logic [DATA_W-1:0] memWdata,
  output logic [OP_W-1:0]   opcode,
  output logic [ADDR_W-1:0] dbgPc,
  output logic [DATA_W-1:0] dbgAcc,
  output logic [ADDR_W-1:0] dbgMar,
  output logic [DATA_W-1:0] dbgMdr,
  output logic [DATA_W-1:0] dbgIr,
  output logic              dbgEq,
  output logic              dbgLt
);

  localparam int PAD_W = DATA_W - ADDR_W;

  logic [ADDR_W-1:0] pc, mar;
  logic [DATA_W-1:0] acc, mdr, ir;
  logic              eqFlag, ltFlag;
  logic [ADDR_W-1:0] operand;
  logic [DATA_W-1:0] opdExt;

  assign operand = ir[ADDR_W-1:0];
  assign opcode  = ir[DATA_W-1 -: OP_W];
  assign opdExt  = {{PAD_W{1'b0}}, operand};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc <= '0; mar <= '0; acc <= '0; mdr <= '0; ir <= '0;
      eqFlag <= 1'b0; ltFlag <= 1'b0;
    end else begin
      if (ctrl.marFromPc)       mar <= pc;
      else if (ctrl.marFromOpd) mar <= operand;
      if (ctrl.mdrCapture) mdr <= memRdata;
      if (ctrl.pcInc)       pc <= pc + 1'b1;
      else if (ctrl.pcJump) pc <= operand;
      if (ctrl.irLoad) ir <= mdr;
      if (ctrl.accAdd)       acc <= acc + opdExt;
      else if (ctrl.accLoad) acc <= memRdata;
      if (ctrl.flagsSet) begin
        eqFlag <= (acc == opdExt);
        ltFlag <= (acc < opdExt);
      end
    end
  end

  assign memAddr  = mar;
  assign memRd    = ctrl.memRead;
  assign memWr    = ctrl.memWrite;
  assign memWdata = acc;
  assign dbgPc    = pc;
  assign dbgAcc   = acc;
  assign dbgMar   = mar;
  assign dbgMdr   = mdr;
  assign dbgIr    = ir;
  assign dbgEq    = eqFlag;
  assign dbgLt    = ltFlag;

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.pcInc |=> pc == ADDR_W'($past(pc) + 1'b1)); // R2
  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.pcJump |=> pc == $past(operand)); // R8
  AST_CMP_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.flagsSet |=> $stable(acc)); // R7
  AST_FETCH_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.marFromPc |=> memRd && memAddr == $past(pc)); // R1
  AST_NO_RD_WR_CLASH: assert property (@(posedge clk) disable iff (!rstN)
    memRd |-> !memWr); // R12

endmodule

// File: rtl/acc_core.sv
module acc_core #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12,
  parameter int OP_W   = DATA_W - ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRd,
  output logic              memWr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              halted,
  output logic [ADDR_W-1:0] dbgPc,
  output logic [DATA_W-1:0] dbgAcc,
  output logic [ADDR_W-1:0] dbgMar,
  output logic [DATA_W-1:0] dbgMdr,
  output logic [DATA_W-1:0] dbgIr,
  output logic              dbgEq,
  output logic              dbgLt
);

  acc_core_pkg::ctrl_t ctrl;
  logic [OP_W-1:0]     opcode;

  acc_control #(.OP_W(OP_W)) uCtrl (
    .clk(clk), .rstN(rstN), .opcode(opcode), .ctrl(ctrl), .halted(halted)
  );

  acc_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .OP_W(OP_W)) uPath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .memRdata(memRdata),
    .memAddr(memAddr), .memRd(memRd), .memWr(memWr), .memWdata(memWdata),
    .opcode(opcode), .dbgPc(dbgPc), .dbgAcc(dbgAcc), .dbgMar(dbgMar),
    .dbgMdr(dbgMdr), .dbgIr(dbgIr), .dbgEq(dbgEq), .dbgLt(dbgLt)
  );

endmodule

// File: tb/tb_acc_core.sv
`timescale 1ns/1ps
module tb_acc_core;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] memAddr;
  logic        memRd, memWr;
  logic [15:0] memWdata;
  logic [15:0] memRdata = '0;
  logic        halted;
  logic [11:0] dbgPc, dbgMar;
  logic [15:0] dbgAcc, dbgMdr, dbgIr;
  logic        dbgEq, dbgLt;

  int checks = 0;
  int errors = 0;
  int wrCount = 0;
  logic [15:0] mem [256];

  always #10 clk = ~clk;

  acc_core dut (
    .clk(clk), .rstN(rstN), .memAddr(memAddr), .memRd(memRd), .memWr(memWr),
    .memWdata(memWdata), .memRdata(memRdata), .halted(halted), .dbgPc(dbgPc),
    .dbgAcc(dbgAcc), .dbgMar(dbgMar), .dbgMdr(dbgMdr), .dbgIr(dbgIr),
    .dbgEq(dbgEq), .dbgLt(dbgLt)
  );

  // {addr[61:50], word[49:34], cycles[33:30], acc[29:14], eq[13], lt[12], pc[11:0]}
  localparam int NV = 14;
  localparam logic [61:0] VEC [NV] = '{
    {12'h000, 16'h1040, 4'd7, 16'h1234, 1'b0, 1'b0, 12'h001},
    {12'h001, 16'h30FF, 4'd5, 16'h1333, 1'b0, 1'b0, 12'h002},
    {12'h002, 16'h4333, 4'd5, 16'h1333, 1'b0, 1'b0, 12'h003},
    {12'h003, 16'h2041, 4'd6, 16'h1333, 1'b0, 1'b0, 12'h004},
    {12'h004, 16'h1042, 4'd7, 16'h0005, 1'b0, 1'b0, 12'h005},
    {12'h005, 16'h4005, 4'd5, 16'h0005, 1'b1, 1'b0, 12'h006},
    {12'h006, 16'h4006, 4'd5, 16'h0005, 1'b0, 1'b1, 12'h007},
    {12'h007, 16'h7ABC, 4'd5, 16'h0005, 1'b0, 1'b1, 12'h008},
    {12'h008, 16'h3FFF, 4'd5, 16'h1004, 1'b0, 1'b1, 12'h009},
    {12'h009, 16'h1043, 4'd7, 16'hFFFF, 1'b0, 1'b1, 12'h00A},
    {12'h00A, 16'h3002, 4'd5, 16'h0001, 1'b0, 1'b1, 12'h00B},
    {12'h00B, 16'h5020, 4'd5, 16'h0001, 1'b0, 1'b1, 12'h020},
    {12'h020, 16'h2044, 4'd6, 16'h0001, 1'b0, 1'b1, 12'h021},
    {12'h021, 16'hF000, 4'd5, 16'h0001, 1'b0, 1'b1, 12'h022}
  };

  // memory model: one-cycle read latency, single process owns the array
  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    for (int i = 0; i < NV; i++) mem[VEC[i][57:50]] = VEC[i][49:34];
    mem[8'h40] = 16'h1234;
    mem[8'h42] = 16'h0005;
    mem[8'h43] = 16'hFFFF;
    forever begin
      @(posedge clk);
      if (memRd) memRdata <= mem[memAddr[7:0]];
      if (memWr) begin
        mem[memAddr[7:0]] <= memWdata;
        wrCount <= wrCount + 1;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string tagFor(input logic [3:0] op);
    case (op)
      4'd1:    return "R5 load";
      4'd2:    return "R6 store";
      4'd3:    return "R4 add";
      4'd4:    return "R7 compare";
      4'd5:    return "R8 jump";
      4'd15:   return "R9 halt";
      default: return "R10 no-op";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int idle;
    repeat (3) @(negedge clk);
    chk("R11 pc", dbgPc, 0);
    chk("R11 acc", dbgAcc, 0);
    chk("R11 flags", {dbgEq, dbgLt}, 0);
    chk("R11 strobes", {memRd, memWr, halted}, 0);

    rstN = 1'b1;
    @(negedge clk);
    chk("R1 read strobe", memRd, 1);
    chk("R1 address from pc", memAddr, 0);
    chk("R11 first fetch pc", dbgPc, 0);
    @(negedge clk);
    chk("R1 single read", memRd, 0);
    chk("R2 pc before capture", dbgPc, 0);
    @(negedge clk);
    chk("R1 mdr word", dbgMdr, 16'h1040);
    chk("R2 pc incremented in fetch", dbgPc, 1);

    for (int i = 0; i < NV; i++) begin
      int n;
      string tag;
      n = int'(VEC[i][33:30]);
      if (i == 0) n = n - 3;
      repeat (n) @(negedge clk);
      tag = tagFor(VEC[i][49:46]);
      chk("R3 ir", dbgIr, VEC[i][49:34]);
      chk({tag, " acc R12"}, dbgAcc, VEC[i][29:14]);
      chk({tag, " eq"}, dbgEq, VEC[i][13]);
      chk({tag, " lt"}, dbgLt, VEC[i][12]);
      chk({tag, " pc"}, dbgPc, VEC[i][11:0]);
    end

    chk("R9 halted", halted, 1);
    idle = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (memRd || memWr) idle++;
    end
    chk("R9 no access while halted", idle, 0);
    chk("R9 pc frozen", dbgPc, 12'h022);
    chk("R6 store data 1", mem[8'h41], 16'h1333);
    chk("R6 store data 2", mem[8'h44], 16'h0001);
    chk("R6 write count", wrCount, 2);
    chk("R5 source intact", mem[8'h40], 16'h1234);

    rstN = 1'b0;
    @(negedge clk);
    chk("R11 halt cleared", halted, 0);
    chk("R11 pc cleared", dbgPc, 0);
    chk("R11 acc cleared", dbgAcc, 0);
    chk("R11 lt cleared", dbgLt, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R11 restart fetch", {memRd, memAddr}, {1'b1, 12'h000});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule